// File: doc/BRIEF.md
# Magnitude-Bit Duty-Cycle Gain Controller

This block closes a digital automatic gain control loop for one intermediate-frequency chain of a satellite-navigation receiver. A 3-bit sign/magnitude ADC delivers one code per sample strobe. The block estimates received power without measuring amplitude. It counts how many samples in a fixed measurement window have the upper magnitude bit set, which is the rate at which the signal crosses the ADC threshold. At the end of each window it moves a 0..50 dB gain code for an external variable-gain amplifier by one step, so that this rate stays between two programmable percentages.

A small register port lets a host program the lower and upper percentage bounds. The host can also force a fixed gain with adaptation switched off, and read back the gain currently applied. The loop is meant to run at the sample rate of 64 × 1.023 MHz. The window length is a power of two set by a parameter and defaults to 1024 samples.

Top module: `magbit_agc`

## Requirements
- R1: Each sample code carries the sign in bit 2, the upper magnitude bit in bit 1 and the lower magnitude bit in bit 0. Only bit 1 contributes to the count, and the sign and lower magnitude bits have no effect on the gain.
- R2: A window consists of exactly 2^WIN_LOG2 samples accepted while `smp_valid` is high. Codes presented while `smp_valid` is low are not counted.
- R3: At the end of a window the count is compared with round(pct × 2^WIN_LOG2 / 100) for each bound, with halves rounded up. A count above the upper threshold lowers the gain by 1 and a count below the lower threshold raises it by 1. A count on either threshold or between them leaves the gain unchanged. The new gain appears on `gain_code` after the second rising edge that follows the edge accepting the window's last sample.
- R4: The gain code stays within 0..50. It holds at 50 when asked to rise and at 0 when asked to fall, and never wraps.
- R5: After reset the gain is 25, the lower bound is 26 %, the upper bound is 40 %, manual mode is off and the forced gain is 20.
- R6: Register map, written when `cfg_wr` is high at a rising edge and read combinationally on `cfg_rdata` for the address on `cfg_addr`:
  - address 0 holds the lower bound in bits 6:0.
  - address 1 holds the upper bound in bits 6:0.
  - address 2 holds manual enable in bit 7 and the forced gain in bits 5:0.
  - address 3 is a read-only readback of the gain in bits 5:0.
  - Unused bits read 0.
- R7: A write that would leave the lower bound above the upper bound is ignored and both bounds keep their previous values. Equal bounds are accepted.
- R8: While manual mode is on, the gain equals the forced value from the second rising edge after the enabling write. The window count is held cleared and samples are ignored. A forced value above 50 is stored as 50.
- R9: When manual mode is turned off, adaptation starts from the forced gain with a fresh, empty window.
- R10: In automatic mode the gain changes by at most one step per window and does not change between window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, code accepted when high |
| smp_code | input | 3 | ADC code {sign, mag_hi, mag_lo} |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| gain_code | output | 6 | VGA gain in dB, 0..50 |

## Verification
The bench builds the block with WIN_LOG2 = 6, so that a window is 64 samples long. This keeps each window short enough that the gain can be driven from its reset value to both rails, and kept there, well within the cycle budget. With 64 samples the default bounds become thresholds of 17 and 26. Bounds of 30 % and 45 % become 19 and 29, which lets the bench place counts exactly on each threshold and one past it. Random windows with random strobe gaps exercise the count under irregular sample arrival.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;

    localparam int PCT_W  = 7;
    localparam int GAIN_W = 6;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic [PCT_W-1:0]  lo_pct;
        logic [PCT_W-1:0]  hi_pct;
        logic              manual;
        logic [GAIN_W-1:0] forced;
    } cfg_state_t;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_GAIN = 2'd3;

endpackage

// File: rtl/agc_win_counter.sv
`timescale 1ns/1ps
module agc_win_counter #(
    parameter int WIN_LOG2 = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                smp_valid,
    input  logic                mag_hi,
    output logic                win_done,
    output logic [WIN_LOG2:0]   win_total
);
    localparam int CW = WIN_LOG2 + 1;
    localparam logic [WIN_LOG2-1:0] LAST_IDX = {WIN_LOG2{1'b1}};

    typedef struct packed {
        logic [WIN_LOG2-1:0] idx;
        logic [CW-1:0]       acc;
        logic                done;
        logic [CW-1:0]       total;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d.idx = '0;
            st_d.acc = '0;
        end else if (smp_valid) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.done  = 1'b1;
                st_d.total = st_q.acc + CW'(mag_hi);
                st_d.idx   = '0;
                st_d.acc   = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.acc = st_q.acc + CW'(mag_hi);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_done  = st_q.done;
    assign win_total = st_q.total;

endmodule

// File: rtl/agc_thresh.sv
`timescale 1ns/1ps
module agc_thresh
    import agc_pkg::*;
#(
    parameter int WIN_LOG2 = 10
) (
    input  logic [PCT_W-1:0]  lo_pct,
    input  logic [PCT_W-1:0]  hi_pct,
    input  logic [WIN_LOG2:0] total,
    output step_e             step
);
    localparam int TW = PCT_W + WIN_LOG2 + 2;

    logic [TW-1:0] lo_thr;
    logic [TW-1:0] hi_thr;
    logic [TW-1:0] tot_ext;

    always_comb begin
        lo_thr  = ((TW'(lo_pct) << WIN_LOG2) + TW'(50)) / TW'(100);
        hi_thr  = ((TW'(hi_pct) << WIN_LOG2) + TW'(50)) / TW'(100);
        tot_ext = TW'(total);
        if (tot_ext > hi_thr) begin
            step = STEP_DOWN;
        end else if (tot_ext < lo_thr) begin
            step = STEP_UP;
        end else begin
            step = STEP_HOLD;
        end
    end

endmodule

// File: rtl/agc_gain_ctrl.sv
`timescale 1ns/1ps
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int GAIN_MAX = 50,
    parameter int GAIN_RST = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              manual,
    input  logic [GAIN_W-1:0] forced,
    input  logic              win_done,
    input  step_e             step,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] G_MAX = GAIN_W'(GAIN_MAX);
    localparam logic [GAIN_W-1:0] G_RST = GAIN_W'(GAIN_RST);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
    } gain_state_t;

    gain_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (manual) begin
            st_d.gain = forced;
        end else if (win_done) begin
            unique case (step)
                STEP_UP: begin
                    if (st_q.gain < G_MAX) st_d.gain = st_q.gain + 1'b1;
                end
                STEP_DOWN: begin
                    if (st_q.gain != '0) st_d.gain = st_q.gain - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gain <= G_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain = st_q.gain;

endmodule

// File: rtl/agc_cfg_regs.sv
`timescale 1ns/1ps
module agc_cfg_regs
    import agc_pkg::*;
#(
    parameter int GAIN_MAX   = 50,
    parameter int LO_RST     = 26,
    parameter int HI_RST     = 40,
    parameter int FORCED_RST = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [GAIN_W-1:0] gain,
    output cfg_state_t        cfg,
    output logic [7:0]        cfg_rdata
);
    localparam logic [GAIN_W-1:0] G_MAX = GAIN_W'(GAIN_MAX);

    cfg_state_t st_d, st_q;
    logic [PCT_W-1:0]  wr_pct;
    logic [GAIN_W-1:0] wr_gain;

    always_comb begin
        st_d    = st_q;
        wr_pct  = cfg_wdata[PCT_W-1:0];
        wr_gain = cfg_wdata[GAIN_W-1:0];
        if (cfg_wr) begin
            unique case (cfg_addr)
                ADDR_LO: begin
                    if (wr_pct <= st_q.hi_pct) st_d.lo_pct = wr_pct;
                end
                ADDR_HI: begin
                    if (wr_pct >= st_q.lo_pct) st_d.hi_pct = wr_pct;
                end
                ADDR_CTRL: begin
                    st_d.manual = cfg_wdata[7];
                    st_d.forced = (wr_gain > G_MAX) ? G_MAX : wr_gain;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (cfg_addr)
            ADDR_LO:   cfg_rdata = {1'b0, st_q.lo_pct};
            ADDR_HI:   cfg_rdata = {1'b0, st_q.hi_pct};
            ADDR_CTRL: cfg_rdata = {st_q.manual, 1'b0, st_q.forced};
            default:   cfg_rdata = {2'b00, gain};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo_pct <= PCT_W'(LO_RST);
            st_q.hi_pct <= PCT_W'(HI_RST);
            st_q.manual <= 1'b0;
            st_q.forced <= GAIN_W'(FORCED_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q;

endmodule

// File: rtl/magbit_agc.sv
`timescale 1ns/1ps
module magbit_agc
    import agc_pkg::*;
#(
    parameter int WIN_LOG2   = 10,
    parameter int GAIN_MAX   = 50,
    parameter int GAIN_RST   = 25,
    parameter int LO_RST     = 26,
    parameter int HI_RST     = 40,
    parameter int FORCED_RST = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [2:0]  smp_code,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    output logic [5:0]  gain_code
);
    localparam int MAG_HI_BIT = 1;

    cfg_state_t         cfg;
    logic               win_done;
    logic [WIN_LOG2:0]  win_total;
    step_e              step;
    logic [GAIN_W-1:0]  gain;

    agc_cfg_regs #(
        .GAIN_MAX   (GAIN_MAX),
        .LO_RST     (LO_RST),
        .HI_RST     (HI_RST),
        .FORCED_RST (FORCED_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .gain      (gain),
        .cfg       (cfg),
        .cfg_rdata (cfg_rdata)
    );

    agc_win_counter #(
        .WIN_LOG2 (WIN_LOG2)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg.manual),
        .smp_valid (smp_valid),
        .mag_hi    (smp_code[MAG_HI_BIT]),
        .win_done  (win_done),
        .win_total (win_total)
    );

    agc_thresh #(
        .WIN_LOG2 (WIN_LOG2)
    ) u_thr (
        .lo_pct (cfg.lo_pct),
        .hi_pct (cfg.hi_pct),
        .total  (win_total),
        .step   (step)
    );

    agc_gain_ctrl #(
        .GAIN_MAX (GAIN_MAX),
        .GAIN_RST (GAIN_RST)
    ) u_gain (
        .clk      (clk),
        .rst_n    (rst_n),
        .manual   (cfg.manual),
        .forced   (cfg.forced),
        .win_done (win_done),
        .step     (step),
        .gain     (gain)
    );

    assign gain_code = gain;

endmodule

// File: rtl/magbit_agc_chk.sv
`timescale 1ns/1ps
module magbit_agc_chk #(
    parameter int GAIN_MAX = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] gain,
    input logic       manual,
    input logic [5:0] forced,
    input logic [6:0] lo_pct,
    input logic [6:0] hi_pct,
    input logic       win_done
);
    p_gain_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(gain) <= GAIN_MAX);

    p_bounds_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_pct <= hi_pct);

    p_manual_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        manual |=> gain == $past(forced));

    p_manual_no_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        manual |=> !win_done);

    p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && !win_done) |=> gain == $past(gain));

    p_single_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && win_done) |=>
            (gain == $past(gain)) || (gain == $past(gain) + 6'd1) || (gain + 6'd1 == $past(gain)));

    p_forced_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(forced) <= GAIN_MAX);

endmodule

bind magbit_agc magbit_agc_chk #(
    .GAIN_MAX (GAIN_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gain     (gain),
    .manual   (cfg.manual),
    .forced   (cfg.forced),
    .lo_pct   (cfg.lo_pct),
    .hi_pct   (cfg.hi_pct),
    .win_done (win_done)
);

// File: tb/magbit_agc_bench.sv
`timescale 1ns/1ps
module magbit_agc_bench;
    localparam int WL   = 6;
    localparam int NWIN = 1 << WL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [2:0] smp_code = 3'b000;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic [5:0] gain_code;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_gain = 25, m_lo = 26, m_hi = 40, m_forced = 20;
    bit m_manual = 1'b0;

    always #10 clk = ~clk;

    magbit_agc #(.WIN_LOG2(WL)) u_magbit_agc (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .gain_code(gain_code)
    );

    function automatic int thr(input int pct);
        return (pct * NWIN + 50) / 100;
    endfunction

    function automatic int next_gain(input int g, input int k, input int lo, input int hi);
        if (k > thr(hi)) return (g > 0) ? g - 1 : 0;
        if (k < thr(lo)) return (g < 50) ? g + 1 : 50;
        return g;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, input string req, input int exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, int'(cfg_rdata), exp);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 2'd0 && int'(d[6:0]) <= m_hi) m_lo = int'(d[6:0]);
        if (a == 2'd1 && int'(d[6:0]) >= m_lo) m_hi = int'(d[6:0]);
        if (a == 2'd2) begin
            m_manual = d[7];
            m_forced = (int'(d[5:0]) > 50) ? 50 : int'(d[5:0]);
            if (m_manual) m_gain = m_forced;
        end
    endtask

    // Sends n samples of which k have the upper magnitude bit set.
    // fixed_other >= 0 forces sign/lower-magnitude bits; gaps carry mag bit set.
    task automatic send_samples(input int n, input int k, input int fixed_other, input bit gaps);
        int r = k;
        for (int s = n; s > 0; s--) begin
            if (gaps && ($urandom % 4) == 0) begin
                @(negedge clk);
                smp_valid = 1'b0;
                smp_code  = 3'b111;
            end
            @(negedge clk);
            smp_valid = 1'b1;
            smp_code[1] = (int'($urandom % s) < r);
            if (smp_code[1]) r--;
            if (fixed_other >= 0) begin
                smp_code[2] = fixed_other[1];
                smp_code[0] = fixed_other[0];
            end else begin
                smp_code[2] = $urandom % 2;
                smp_code[0] = $urandom % 2;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
        smp_code  = 3'b111;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic window(input string req, input int k, input int other, input bit gaps);
        send_samples(NWIN, k, other, gaps);
        if (!m_manual) m_gain = next_gain(m_gain, k, m_lo, m_hi);
        check(req, int'(gain_code), m_gain);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A5C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5 reset state
        #1 check("R5 gain", int'(gain_code), 25);
        read_reg(2'd0, "R5 lo", 26);
        read_reg(2'd1, "R5 hi", 40);
        read_reg(2'd2, "R5 ctrl", 20);
        read_reg(2'd3, "R6 gain readback", 25);

        // R1 sign and lower magnitude bits ignored
        window("R1 no mag_hi, others set", 0, 3, 1'b0);
        window("R1 all mag_hi, others clear", NWIN, 0, 1'b0);
        // R2 gaps carry mag_hi=1 and must not count
        window("R2 gapped low-rate window", 10, -1, 1'b1);

        // R7 ignored bound writes
        cfg_write(2'd0, 8'd50);
        read_reg(2'd0, "R7 lo kept", 26);
        cfg_write(2'd1, 8'd10);
        read_reg(2'd1, "R7 hi kept", 40);
        cfg_write(2'd1, 8'd45);
        cfg_write(2'd0, 8'd30);
        read_reg(2'd0, "R6 lo written", 30);
        read_reg(2'd1, "R6 hi written", 45);

        // R3 threshold boundaries: lo thr 19, hi thr 29
        window("R3 on lower threshold", 19, -1, 1'b0);
        window("R3 one below lower", 18, -1, 1'b0);
        window("R3 on upper threshold", 29, -1, 1'b0);
        window("R3 one above upper", 30, -1, 1'b1);

        // R8 manual entry mid-window, clamp
        send_samples(30, 30, -1, 1'b0);
        cfg_write(2'd2, 8'h80 | 8'd40);
        @(negedge clk);
        check("R8 forced gain", int'(gain_code), 40);
        send_samples(20, 20, -1, 1'b0);
        check("R8 samples ignored", int'(gain_code), 40);
        cfg_write(2'd2, 8'h80 | 8'd63);
        @(negedge clk);
        check("R8 clamp", int'(gain_code), 50);
        read_reg(2'd2, "R8 ctrl readback", 128 + 50);
        cfg_write(2'd2, 8'h80 | 8'd40);
        // R9 leave manual, fresh window
        cfg_write(2'd2, 8'd40);
        window("R9 resume from forced", 5, -1, 1'b0);

        // R4 saturation high
        cfg_write(2'd2, 8'h80 | 8'd49);
        cfg_write(2'd2, 8'd49);
        window("R4 rise to max", 0, -1, 1'b0);
        window("R4 hold at max", 0, -1, 1'b0);
        // R4 saturation low
        cfg_write(2'd2, 8'h80 | 8'd1);
        cfg_write(2'd2, 8'd1);
        window("R4 fall to zero", NWIN, -1, 1'b0);
        window("R4 hold at zero", NWIN, -1, 1'b0);

        // R10 random windows with random bound writes
        for (int w = 0; w < 40; w++) begin
            if (($urandom % 5) == 0) cfg_write(2'(1 + ($urandom % 2) - 1), 8'($urandom % 70));
            window("R10 random window", int'($urandom % (NWIN + 1)), -1, 1'b1);
        end
        read_reg(2'd0, "R7 lo after random", m_lo);
        read_reg(2'd1, "R7 hi after random", m_hi);
        read_reg(2'd3, "R6 final readback", m_gain);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule